// File: doc/BRIEF.md
# Sectored page-walk cache

This block caches page-table entries for a page-table walker. Each cache line holds one tag, one address-space identifier, a prefetch flag and several sectors, one for each page-table entry of a single memory burst. A refill writes a whole line in one clock. It takes a virtual page number, an address-space identifier, the walk level at which the entries were read and the concatenated 64-bit entries.

At refill time each entry is checked against the fault rules, including superpage misalignment. The line keeps a valid bit for each sector, which is set only when the entry is usable for the kind of line it sits in. The parameter `LEAF_LINE` picks the line kind: 1 for a line of leaf entries, 0 for a line of pointer entries. The parameter `LEVEL` picks which nine-bit field of the page number supplies the sector index.

A lookup is combinational. It takes a page number and an address-space identifier and returns a hit, the physical page number of the indexed sector and that line's prefetch flag. The walker owns line selection for refills and decides when to flush.

Top module: `pwc_sector_cache`

## Requirements
- R1: After reset no lookup hits.
- R2: After a refill, a lookup whose tag, identifier and sector index match returns a hit in the next cycle. The tag is the page number above the sector index. With the default `LEVEL`=2 the sector index is page-number bits [1:0]. The returned page number is entry i's bits [53:10], where entry i is refill data bits [64i+63:64i].
- R3: A lookup whose tag differs from the stored tag misses.
- R4: A lookup with a different identifier misses, unless the ignore-identifier input is 1, in which case it hits.
- R5: An entry with bit 0 (valid) clear makes its sector invalid, so lookups of that sector miss.
- R6: An entry with bit 2 (write) set and bit 1 (read) clear makes its sector invalid.
- R7: An entry with any of bits 1 to 3 (read, write, execute) set is a leaf. A leaf read at walk level 1 is faulty when its page-number bits [8:0] are non-zero. A leaf read at walk level 0 is faulty when its page-number bits [17:0] are non-zero. A leaf read at walk level 2 or 3 is never misaligned.
- R8: In a leaf line (default), a well-formed non-leaf entry gives an invalid sector. In a pointer line, a well-formed leaf gives an invalid sector.
- R9: On a hit, the prefetch output equals the flag given with that line's refill.
- R10: A flush clears every line in one clock. A refill in the same cycle as a flush leaves no valid line.
- R11: A refill replaces only the line it names; the other lines keep hitting.
- R12: When several lines hit, the one with the lowest line index supplies the page number and the prefetch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all line valid bits |
| rf_valid | input | 1 | Refill strobe |
| rf_line | input | LINE_W | Line to refill |
| rf_vpn | input | VPN_W | Page number of the refill |
| rf_asid | input | ASID_W | Identifier of the refill |
| rf_level | input | 2 | Walk level of the entries (0 top, 2 base) |
| rf_prefetch | input | 1 | Prefetch flag to store |
| rf_data | input | 64*SECTORS | Concatenated entries, entry i at [64i+63:64i] |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_ignore_asid | input | 1 | Skip the identifier compare |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number of the hit sector |
| lk_prefetch | output | 1 | Prefetch flag of the hit line |

## Verification
The bench fills lines with mixed entries and probes each sector on its own. A design that read the wrong 64-bit slice, or skipped the invalid-entry, write-without-read, non-leaf or misalignment rules, would return a hit with a wrong page number or hit on a sector that should miss. Misalignment is tested at all three walk levels with page numbers just off alignment. A design that applied the level-1 mask at level 0, or checked level 2 at all, would give the wrong valid bits. Further cases cover an identifier mismatch with and without the ignore input, two lines holding the same tag (where a design with the wrong priority returns the higher line's page number), a refill that must leave the other lines intact, and a flush raised together with a refill, which must leave nothing valid.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int PTE_W      = 64;
  localparam int FIELD_W    = 9;
  localparam int PPN_W      = 44;
  localparam int PPN_LSB    = 10;

  // Entry layout, MSB first
  typedef struct packed {
    logic [9:0]  rsvd;
    logic [43:0] ppn;
    logic [1:0]  rsw;
    logic        d;
    logic        a;
    logic        g;
    logic        u;
    logic        x;
    logic        w;
    logic        r;
    logic        v;
  } pte_t;
endpackage

// File: rtl/pwc_rst_sync.sv
module pwc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwc_pte_check.sv
module pwc_pte_check
  import pwc_pkg::*;
#(
  parameter bit LEAF_LINE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [PTE_W-1:0] pte_raw,
  input  logic [1:0]       level,
  output logic             sector_ok
);
  pte_t pte;
  logic is_leaf;
  logic misaligned;
  logic faulty;
  logic unused_bits;

  assign pte         = pte_t'(pte_raw);
  assign unused_bits = ^{pte.rsvd, pte.ppn[PPN_W-1:2*FIELD_W], pte.rsw,
                         pte.d, pte.a, pte.g, pte.u};

  assign is_leaf = pte.r | pte.w | pte.x;

  always_comb begin
    unique case (level)
      2'd0:    misaligned = |pte.ppn[2*FIELD_W-1:0];
      2'd1:    misaligned = |pte.ppn[FIELD_W-1:0];
      default: misaligned = 1'b0;
    endcase
  end

  assign faulty = !pte.v || (pte.w && !pte.r) || (is_leaf && misaligned);

  generate
    if (LEAF_LINE) begin : g_leaf
      assign sector_ok = !faulty && is_leaf;
    end else begin : g_ptr
      assign sector_ok = !faulty && !is_leaf;
    end
  endgenerate

  // R5: an entry without its valid bit never yields a usable sector
  p_invalid_pte_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !pte_raw[0] |-> !sector_ok);

  // R7: a level-1 leaf with low page bits set is rejected
  p_misaligned_l1_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && level == 2'd1 && (|pte_raw[3:1]) && (|pte_raw[PPN_LSB +: FIELD_W])
    |-> !sector_ok);
endmodule

// File: rtl/pwc_line.sv
module pwc_line #(
  parameter int TAG_W   = 25,
  parameter int ASID_W  = 16,
  parameter int PPN_W   = 44,
  parameter int SECTORS = 4,
  localparam int IDX_W  = $clog2(SECTORS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic                     wr_prefetch,
  input  logic [SECTORS*PPN_W-1:0] wr_ppn,
  input  logic [SECTORS-1:0]       wr_sok,
  input  logic [TAG_W-1:0]         lk_tag,
  input  logic [IDX_W-1:0]         lk_idx,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic                     lk_ignore_asid,
  output logic                     hit,
  output logic [PPN_W-1:0]         ppn,
  output logic                     prefetch
);
  logic               valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q;
  logic [ASID_W-1:0]  asid_q;
  logic               pf_q;
  logic [SECTORS-1:0] sok_q;
  logic [PPN_W-1:0]   ppn_q [SECTORS];

  // next state of the line valid bit; flush has priority
  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = 1'b0;
    else if (wr_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // payload: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q  <= wr_tag;
      asid_q <= wr_asid;
      pf_q   <= wr_prefetch;
      sok_q  <= wr_sok;
      for (int s = 0; s < SECTORS; s++) ppn_q[s] <= wr_ppn[s*PPN_W +: PPN_W];
    end
  end

  logic tag_eq, asid_eq;
  assign tag_eq   = (tag_q == lk_tag);
  assign asid_eq  = lk_ignore_asid || (asid_q == lk_asid);
  assign hit      = valid_q && tag_eq && asid_eq && sok_q[lk_idx];
  assign ppn      = ppn_q[lk_idx];
  assign prefetch = pf_q;

  // R11: a refill without flush leaves the line valid
  p_valid_after_refill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flush |=> valid_q);

  // R11: a line not written keeps its tag
  p_idle_line_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tag_q));
endmodule

// File: rtl/pwc_sector_cache.sv
module pwc_sector_cache
  import pwc_pkg::*;
#(
  parameter int SECTORS   = 4,
  parameter int LINES     = 8,
  parameter int VPN_W     = 27,
  parameter int ASID_W    = 16,
  parameter int LEVEL     = 2,
  parameter bit LEAF_LINE = 1'b1,
  localparam int LINE_W   = $clog2(LINES),
  localparam int IDX_W    = $clog2(SECTORS),
  localparam int FIELD_LSB = FIELD_W * (2 - LEVEL),
  localparam int TAG_W    = VPN_W - FIELD_LSB - IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     rf_valid,
  input  logic [LINE_W-1:0]        rf_line,
  input  logic [VPN_W-1:0]         rf_vpn,
  input  logic [ASID_W-1:0]        rf_asid,
  input  logic [1:0]               rf_level,
  input  logic                     rf_prefetch,
  input  logic [SECTORS*PTE_W-1:0] rf_data,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic                     lk_ignore_asid,
  output logic                     lk_hit,
  output logic [PPN_W-1:0]         lk_ppn,
  output logic                     lk_prefetch
);
  logic rst_sync_n;

  pwc_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // refill-side decode of each entry
  logic [SECTORS-1:0]       sok;
  logic [SECTORS*PPN_W-1:0] rf_ppns;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    pwc_pte_check #(.LEAF_LINE(LEAF_LINE)) chk_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .chk_en    (rf_valid),
      .pte_raw   (rf_data[s*PTE_W +: PTE_W]),
      .level     (rf_level),
      .sector_ok (sok[s])
    );
    assign rf_ppns[s*PPN_W +: PPN_W] = rf_data[s*PTE_W + PPN_LSB +: PPN_W];
  end

  logic [TAG_W-1:0] rf_tag, lk_tag;
  logic [IDX_W-1:0] lk_idx;
  logic             unused_vpn;

  assign rf_tag = rf_vpn[VPN_W-1 -: TAG_W];
  assign lk_tag = lk_vpn[VPN_W-1 -: TAG_W];
  assign lk_idx = lk_vpn[FIELD_LSB +: IDX_W];
  assign unused_vpn = ^{rf_vpn, lk_vpn};

  logic [LINES-1:0] line_hit;
  logic [LINES-1:0] line_pf;
  logic [PPN_W-1:0] line_ppn [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic wr_en;
    assign wr_en = rf_valid && (rf_line == LINE_W'(l));

    pwc_line #(
      .TAG_W   (TAG_W),
      .ASID_W  (ASID_W),
      .PPN_W   (PPN_W),
      .SECTORS (SECTORS)
    ) line_i (
      .clk            (clk),
      .rst_n          (rst_sync_n),
      .flush          (flush),
      .wr_en          (wr_en),
      .wr_tag         (rf_tag),
      .wr_asid        (rf_asid),
      .wr_prefetch    (rf_prefetch),
      .wr_ppn         (rf_ppns),
      .wr_sok         (sok),
      .lk_tag         (lk_tag),
      .lk_idx         (lk_idx),
      .lk_asid        (lk_asid),
      .lk_ignore_asid (lk_ignore_asid),
      .hit            (line_hit[l]),
      .ppn            (line_ppn[l]),
      .prefetch       (line_pf[l])
    );
  end

  // lowest-index hitting line wins
  always_comb begin
    lk_ppn      = '0;
    lk_prefetch = 1'b0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (line_hit[l]) begin
        lk_ppn      = line_ppn[l];
        lk_prefetch = line_pf[l];
      end
    end
  end

  assign lk_hit = |line_hit;

  // R10: nothing hits in the cycle after a flush
  p_no_hit_after_flush_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(flush) |-> !lk_hit);

  // R1: no hit while the synchronised reset is still asserted
  p_no_hit_in_reset_r1: assert property (@(posedge clk)
    !rst_sync_n |-> !lk_hit);
endmodule

// File: tb/pwc_sector_cache_tb_top.sv
module pwc_sector_cache_tb_top;
  localparam int SECTORS = 4;
  localparam int LINES   = 8;
  localparam int VPN_W   = 27;
  localparam int ASID_W  = 16;
  localparam int PPN_W   = 44;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, rf_valid, rf_prefetch, lk_ignore_asid;
  logic [2:0] rf_line;
  logic [VPN_W-1:0] rf_vpn, lk_vpn;
  logic [ASID_W-1:0] rf_asid, lk_asid;
  logic [1:0] rf_level;
  logic [SECTORS*64-1:0] rf_data;
  logic lk_hit, lk_prefetch;
  logic [PPN_W-1:0] lk_ppn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwc_sector_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rf_valid(rf_valid),
    .rf_line(rf_line), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_level(rf_level),
    .rf_prefetch(rf_prefetch), .rf_data(rf_data), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_ignore_asid(lk_ignore_asid), .lk_hit(lk_hit),
    .lk_ppn(lk_ppn), .lk_prefetch(lk_prefetch)
  );

  function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'h0, ppn, 2'b00, fl};
  endfunction

  task automatic refill(input int line, input logic [VPN_W-1:0] vpn,
                        input logic [ASID_W-1:0] asid, input logic [1:0] lvl,
                        input logic pf, input logic [255:0] data, input logic fl);
    @(negedge clk);
    rf_valid = 1'b1; rf_line = 3'(line); rf_vpn = vpn; rf_asid = asid;
    rf_level = lvl; rf_prefetch = pf; rf_data = data; flush = fl;
    @(negedge clk);
    rf_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic ign, input logic eh, input logic [43:0] ep,
                      input logic epf, input string req);
    @(negedge clk);
    lk_vpn = vpn; lk_asid = asid; lk_ignore_asid = ign;
    #1;
    checks++;
    if (lk_hit !== eh) begin
      errors++;
      $display("FAIL %s hit vpn=%h actual=%b expected=%b", req, vpn, lk_hit, eh);
    end else if (eh && (lk_ppn !== ep || lk_prefetch !== epf)) begin
      errors++;
      $display("FAIL %s ppn/pf vpn=%h actual=%h/%b expected=%h/%b",
               req, vpn, lk_ppn, lk_prefetch, ep, epf);
    end
  endtask

  localparam logic [VPN_W-1:0] VA = 27'h0ABCD0;
  localparam logic [VPN_W-1:0] VB = 27'h001234;
  localparam logic [VPN_W-1:0] VC = 27'h055500;
  localparam logic [VPN_W-1:0] VD = 27'h077770;
  localparam logic [VPN_W-1:0] VE = 27'h033330;
  localparam logic [VPN_W-1:0] VF = 27'h011110;

  task automatic t_reset();
    look(VA, 16'd5, 1'b0, 1'b0, 44'h0, 1'b0, "R1");
    look(VA, 16'd5, 1'b1, 1'b0, 44'h0, 1'b0, "R1");
  endtask

  task automatic t_basic();
    refill(0, VA, 16'd5, 2'd2, 1'b0,
           {mk(44'h103, 8'h0F), mk(44'h102, 8'h0F), mk(44'h101, 8'h0F), mk(44'h100, 8'h0F)}, 1'b0);
    for (int i = 0; i < 4; i++)
      look(VA + 27'(i), 16'd5, 1'b0, 1'b1, 44'h100 + 44'(i), 1'b0, "R2");
  endtask

  task automatic t_tag();
    look(VA ^ 27'h20, 16'd5, 1'b0, 1'b0, 44'h0, 1'b0, "R3");
    look(VA ^ 27'h4000000, 16'd5, 1'b1, 1'b0, 44'h0, 1'b0, "R3");
  endtask

  task automatic t_asid();
    look(VA + 27'd1, 16'd6, 1'b0, 1'b0, 44'h0, 1'b0, "R4");
    look(VA + 27'd1, 16'd6, 1'b1, 1'b1, 44'h101, 1'b0, "R4");
  endtask

  task automatic t_faults_l1();
    refill(1, VB, 16'd7, 2'd1, 1'b0,
           {mk(44'h201, 8'h03), mk(44'h200, 8'h03), mk(44'h400, 8'h05), mk(44'h400, 8'h0E)}, 1'b0);
    look(VB + 27'd0, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R5");
    look(VB + 27'd1, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R6");
    look(VB + 27'd2, 16'd7, 1'b0, 1'b1, 44'h200, 1'b0, "R7");
    look(VB + 27'd3, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R7");
  endtask

  task automatic t_faults_l0();
    refill(2, VC, 16'd7, 2'd0, 1'b0,
           {mk(44'h1, 8'h0B), mk(44'h0, 8'h01), mk(44'h40000, 8'h03), mk(44'h200, 8'h03)}, 1'b0);
    look(VC + 27'd0, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R7");
    look(VC + 27'd1, 16'd7, 1'b0, 1'b1, 44'h40000, 1'b0, "R7");
    look(VC + 27'd2, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R8");
    look(VC + 27'd3, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R7");
  endtask

  task automatic t_level2_pf();
    refill(3, VD, 16'd9, 2'd2, 1'b1,
           {mk(44'h7, 8'h0B), mk(44'h5, 8'h03), mk(44'h3, 8'h03), mk(44'h1, 8'h03)}, 1'b0);
    look(VD + 27'd0, 16'd9, 1'b0, 1'b1, 44'h1, 1'b1, "R7");
    look(VD + 27'd3, 16'd9, 1'b0, 1'b1, 44'h7, 1'b1, "R9");
    look(VA + 27'd2, 16'd5, 1'b0, 1'b1, 44'h102, 1'b0, "R9");
  endtask

  task automatic t_overwrite();
    refill(0, VF, 16'd5, 2'd2, 1'b0,
           {mk(44'h903, 8'h03), mk(44'h902, 8'h03), mk(44'h901, 8'h03), mk(44'h900, 8'h03)}, 1'b0);
    look(VA + 27'd0, 16'd5, 1'b0, 1'b0, 44'h0, 1'b0, "R11");
    look(VF + 27'd2, 16'd5, 1'b0, 1'b1, 44'h902, 1'b0, "R11");
    look(VB + 27'd2, 16'd7, 1'b0, 1'b1, 44'h200, 1'b0, "R11");
    look(VD + 27'd1, 16'd9, 1'b0, 1'b1, 44'h3, 1'b1, "R11");
  endtask

  task automatic t_priority();
    refill(5, VE, 16'd3, 2'd2, 1'b1,
           {4{mk(44'hBBB, 8'h03)}}, 1'b0);
    refill(4, VE, 16'd3, 2'd2, 1'b0,
           {4{mk(44'hAAA, 8'h03)}}, 1'b0);
    look(VE + 27'd1, 16'd3, 1'b0, 1'b1, 44'hAAA, 1'b0, "R12");
  endtask

  task automatic t_flush();
    refill(6, VA, 16'd5, 2'd2, 1'b0, {4{mk(44'h55, 8'h03)}}, 1'b1);
    look(VA + 27'd0, 16'd5, 1'b0, 1'b0, 44'h0, 1'b0, "R10");
    look(VB + 27'd2, 16'd7, 1'b0, 1'b0, 44'h0, 1'b0, "R10");
    look(VE + 27'd0, 16'd3, 1'b1, 1'b0, 44'h0, 1'b0, "R10");
    refill(6, VA, 16'd5, 2'd2, 1'b0, {4{mk(44'h55, 8'h03)}}, 1'b0);
    look(VA + 27'd3, 16'd5, 1'b0, 1'b1, 44'h55, 1'b0, "R10");
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; rf_valid = 1'b0; rf_line = '0; rf_vpn = '0;
    rf_asid = '0; rf_level = '0; rf_prefetch = 1'b0; rf_data = '0;
    lk_vpn = '0; lk_asid = '0; lk_ignore_asid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_tag();
    t_asid();
    t_faults_l1();
    t_faults_l0();
    t_level2_pf();
    t_overwrite();
    t_priority();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule